// File: doc/BRIEF.md
# Select-Line Serial Packet Receiver

This block recovers 16-byte command packets that a host sends by toggling the two select lines of a joypad port. Each write to the joypad port hands the block a 2-bit line code. Both lines low restarts reception. Lines at code 1 mark a one bit, and code 3 is the release that steps to the next bit position. A bit position that is stepped over without a preceding code 1 stays zero. Bits fill a 128-bit buffer starting at the least significant bit. When all 128 positions have been stepped and code 2 is then seen as the stop, the block pulses a one-clock valid strobe. The filled buffer stays on its output.

After a packet, the same lines carry a short handshake that selects which of several attached controllers is reported. Code 1 and code 2 each set a marker. A release seen with both markers set moves the controller index on by one, wrapped by a controller-count mask. Decoding what the packet means is left to the consumer.

Top module: `sel_line_pkt_rx`

## Requirements
- R1: After reset, pkt_valid is 0, ctrl_idx is 0 and pkt_data is all zero. The bit position is "before the first bit", so the first release after reset or after a restart selects bit 0.
- R2: A write of code 0 clears pkt_data to zero and returns the bit position to "before the first bit". This happens even when the previous write was also code 0.
- R3: A write whose nonzero code equals the code of the previous write has no effect. The previous write is code 0 after reset.
- R4: Below 128 stepped bits, code 1 sets pkt_data bit N, where N is the current bit position. Byte N/8 takes bit N%8, so data is LSB-first. Code 1 written before the first release sets nothing.
- R5: Below 128 stepped bits, code 3 advances the bit position by one, and code 2 changes nothing.
- R6: When 128 bits have been stepped, a write of code 2 drives pkt_valid high for exactly one clock. At that point pkt_data holds the received bits. No other event raises pkt_valid.
- R7: Once a packet has been delivered, pkt_data does not change until the next code 0.
- R8: After delivery, code 1 and code 2 each set a marker. Code 3 with both markers set clears them and sets ctrl_idx to (ctrl_idx + 1) AND ctrl_mask. Code 3 with either marker clear leaves ctrl_idx unchanged.
- R9: Every output changes on the clock edge that samples the write. A cycle with line_we low changes nothing, whatever line_val holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_we | input | 1 | Joypad port write strobe |
| line_val | input | 2 | Select-line code carried by the write |
| ctrl_mask | input | 2 | Controller-count mask used to wrap ctrl_idx |
| pkt_data | output | 128 | Received packet buffer, bit 0 first |
| pkt_valid | output | 1 | One-clock strobe when a packet completes |
| ctrl_idx | output | 2 | Currently selected controller |

## Verification
Each of the three results is due one clock after the write: the pkt_data bit set by code 1, the pkt_valid pulse for the stop code, and the ctrl_idx step for the closing release. The bench drives each write on a falling edge and holds it for one full cycle. It samples at the next falling edge, after exactly one rising edge has registered the write. To confirm the strobe lasts one cycle, it samples once more a further falling edge later. Expected packets and controller indices come from arithmetic patterns and a plain mask model kept in the bench.

// File: rtl/sel_line_pkt_pkg.sv
package sel_line_pkt_pkg;

    // line codes carried by bits 5:4 of a joypad port write
    typedef enum logic [1:0] {
        LN_RESTART = 2'd0,
        LN_MARK    = 2'd1,
        LN_STOP    = 2'd2,
        LN_RELEASE = 2'd3
    } line_code_t;

endpackage

// File: rtl/sel_line_filter.sv
module sel_line_filter
    import sel_line_pkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] val,
    output logic       restart,
    output logic       fresh,
    output line_code_t code
);

    typedef struct packed {
        line_code_t last;
    } flt_state_t;

    flt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        code    = line_code_t'(val);
        restart = we && (code == LN_RESTART);
        fresh   = we && (code != st_q.last);
        if (we) begin
            st_d.last = code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= LN_RESTART;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sel_line_seq.sv
module sel_line_seq
    import sel_line_pkt_pkg::*;
#(
    parameter int PKT_BITS = 128,
    parameter int CTRL_W   = 2,
    localparam int POS_W   = $clog2(PKT_BITS),
    localparam int IDX_W   = POS_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              fresh,
    input  line_code_t        code,
    input  logic [CTRL_W-1:0] ctrl_mask,
    output logic              set_en,
    output logic [POS_W-1:0]  set_pos,
    output logic              pkt_valid,
    output logic [CTRL_W-1:0] ctrl_idx
);

    typedef logic signed [IDX_W-1:0] idx_t;

    localparam idx_t IDX_NONE  = idx_t'(-1);
    localparam idx_t IDX_ONE   = idx_t'(1);
    localparam idx_t IDX_FULL  = idx_t'(PKT_BITS);
    localparam idx_t IDX_DONE  = idx_t'(PKT_BITS + 1);
    localparam idx_t IDX_BOTH  = idx_t'(PKT_BITS + 7);
    localparam idx_t MARK_A    = idx_t'(2);
    localparam idx_t MARK_B    = idx_t'(4);
    localparam logic [CTRL_W-1:0] CTRL_ONE = 1;

    typedef struct packed {
        idx_t              idx;
        logic [CTRL_W-1:0] ctrl;
        logic              valid;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        set_en     = 1'b0;
        set_pos    = st_q.idx[POS_W-1:0];
        if (restart) begin
            st_d.idx = IDX_NONE;
        end else if (fresh) begin
            if (st_q.idx > IDX_FULL) begin
                unique case (code)
                    LN_MARK:    st_d.idx = st_q.idx | MARK_A;
                    LN_STOP:    st_d.idx = st_q.idx | MARK_B;
                    LN_RELEASE: begin
                        if (st_q.idx == IDX_BOTH) begin
                            st_d.idx  = st_q.idx & ~(MARK_A | MARK_B);
                            st_d.ctrl = (st_q.ctrl + CTRL_ONE) & ctrl_mask;
                        end
                    end
                    default: ;
                endcase
            end else if (st_q.idx == IDX_FULL) begin
                if (code == LN_STOP) begin
                    st_d.valid = 1'b1;
                    st_d.idx   = IDX_DONE;
                end
            end else begin
                unique case (code)
                    LN_MARK:    set_en   = (st_q.idx >= 0);
                    LN_RELEASE: st_d.idx = st_q.idx + IDX_ONE;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx   <= IDX_NONE;
            st_q.ctrl  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pkt_valid = st_q.valid;
    assign ctrl_idx  = st_q.ctrl;

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx >= IDX_NONE) && (st_q.idx <= IDX_BOTH));

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fresh && !restart) |=> $stable(st_q.idx));

    // R8
    ctrl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_idx) |-> ($past(st_q.idx) == IDX_BOTH));

endmodule

// File: rtl/sel_line_buffer.sv
module sel_line_buffer #(
    parameter int PKT_BITS = 128,
    localparam int POS_W   = $clog2(PKT_BITS),
    localparam int LANES   = PKT_BITS / 8,
    localparam int LANE_AW = POS_W - 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                set_en,
    input  logic [POS_W-1:0]    set_pos,
    output logic [PKT_BITS-1:0] data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_d, lane_q;
        logic       hit;

        always_comb begin
            hit    = set_en && (set_pos[POS_W-1:3] == LANE_AW'(g));
            lane_d = lane_q;
            if (clear) begin
                lane_d = '0;
            end else if (hit) begin
                lane_d = lane_q | (8'b1 << set_pos[2:0]);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign data[8*g +: 8] = lane_q;
    end

    // R2
    buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (data == '0));

    // R7
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !set_en) |=> $stable(data));

endmodule

// File: rtl/sel_line_pkt_rx.sv
module sel_line_pkt_rx
    import sel_line_pkt_pkg::*;
#(
    parameter int PKT_BYTES = 16,
    parameter int CTRL_W    = 2,
    localparam int PKT_BITS = PKT_BYTES * 8,
    localparam int POS_W    = $clog2(PKT_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_we,
    input  logic [1:0]          line_val,
    input  logic [CTRL_W-1:0]   ctrl_mask,
    output logic [PKT_BITS-1:0] pkt_data,
    output logic                pkt_valid,
    output logic [CTRL_W-1:0]   ctrl_idx
);

    logic             restart;
    logic             fresh;
    line_code_t       code;
    logic             set_en;
    logic [POS_W-1:0] set_pos;

    sel_line_filter i_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (line_we),
        .val     (line_val),
        .restart (restart),
        .fresh   (fresh),
        .code    (code)
    );

    sel_line_seq #(
        .PKT_BITS (PKT_BITS),
        .CTRL_W   (CTRL_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .fresh     (fresh),
        .code      (code),
        .ctrl_mask (ctrl_mask),
        .set_en    (set_en),
        .set_pos   (set_pos),
        .pkt_valid (pkt_valid),
        .ctrl_idx  (ctrl_idx)
    );

    sel_line_buffer #(
        .PKT_BITS (PKT_BITS)
    ) i_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .set_en  (set_en),
        .set_pos (set_pos),
        .data    (pkt_data)
    );

    // R9
    quiet_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_we |=> ($stable(pkt_data) && !pkt_valid && $stable(ctrl_idx)));

endmodule

// File: tb/test_sel_line_pkt_rx.sv
`timescale 1ns/1ps
module test_sel_line_pkt_rx;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_we = 1'b0;
    logic [1:0]   line_val = 2'd0;
    logic [1:0]   ctrl_mask = 2'd3;
    logic [127:0] pkt_data;
    logic         pkt_valid;
    logic [1:0]   ctrl_idx;

    int total = 0;
    int bad = 0;
    logic [1:0] exp_ctrl = 2'd0;

    always #10 clk = ~clk;

    sel_line_pkt_rx i_sel_line_pkt_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_we   (line_we),
        .line_val  (line_val),
        .ctrl_mask (ctrl_mask),
        .pkt_data  (pkt_data),
        .pkt_valid (pkt_valid),
        .ctrl_idx  (ctrl_idx)
    );

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one write, held for one full cycle; returns at the falling edge after it registered
    task automatic put(input logic [1:0] v);
        @(negedge clk);
        line_we  = 1'b1;
        line_val = v;
        @(negedge clk);
        line_we  = 1'b0;
    endtask

    function automatic logic [127:0] pattern(input int k);
        logic [127:0] p;
        logic [31:0]  s;
        p = '0;
        case (k)
            0: p = '0;
            1: p = '1;
            2: p = {64{2'b10}};
            3: begin
                s = 32'h1234_5678;
                for (int w = 0; w < 4; w++) begin
                    s = s ^ (s << 13);
                    s = s ^ (s >> 17);
                    s = s ^ (s << 5);
                    p[32*w +: 32] = s;
                end
            end
            default: p = (128'h1 << 127) | (128'h1 << 77) | 128'h1;
        endcase
        return p;
    endfunction

    task automatic ctrl_step(input logic [1:0] mask);
        ctrl_mask = mask;
        put(2'd1);
        put(2'd3);
        chk(ctrl_idx == exp_ctrl, "R8 release without both markers", 128'(ctrl_idx), 128'(exp_ctrl));
        put(2'd2);
        put(2'd3);
        exp_ctrl = (exp_ctrl + 2'd1) & mask;
        chk(ctrl_idx == exp_ctrl, "R8 controller advance", 128'(ctrl_idx), 128'(exp_ctrl));
        chk(pkt_valid == 1'b0, "R6 no strobe in handshake", 128'(pkt_valid), 128'd0);
    endtask

    task automatic send_packet(input logic [127:0] p, input bit dup);
        logic [127:0] part;
        part = '0;
        put(2'd0);
        chk(pkt_data == '0, "R2 restart clears", pkt_data, '0);
        put(2'd1);
        chk(pkt_data == '0, "R4 mark before first release", pkt_data, '0);
        put(2'd3);
        for (int i = 0; i < 128; i++) begin
            put(p[i] ? 2'd1 : 2'd2);
            if (dup && (i % 7 == 0)) put(p[i] ? 2'd1 : 2'd2);
            part[i] = p[i];
            chk(pkt_data == part, "R4 bit set at position", pkt_data, part);
            put(2'd3);
            if (dup && (i % 11 == 0)) put(2'd3);
            chk(pkt_data == part, "R5 release leaves data", pkt_data, part);
        end
        chk(pkt_valid == 1'b0, "R6 no strobe before stop", 128'(pkt_valid), 128'd0);
        put(2'd2);
        chk(pkt_valid == 1'b1, "R6 strobe on stop", 128'(pkt_valid), 128'd1);
        chk(pkt_data == p, "R6 packet contents", pkt_data, p);
        @(negedge clk);
        chk(pkt_valid == 1'b0, "R6 strobe one cycle", 128'(pkt_valid), 128'd0);
        put(2'd1);
        chk(pkt_data == p, "R7 data held after delivery", pkt_data, p);
        put(2'd2);
        put(2'd3);
        exp_ctrl = (exp_ctrl + 2'd1) & ctrl_mask;
        chk(ctrl_idx == exp_ctrl, "R8 advance after packet", 128'(ctrl_idx), 128'(exp_ctrl));
        chk(pkt_data == p, "R7 data held through handshake", pkt_data, p);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            line_val = 2'(c);
            @(negedge clk);
            chk(pkt_data == p && !pkt_valid && ctrl_idx == exp_ctrl, "R9 idle write strobe low",
                pkt_data, p);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pkt_valid == 1'b0, "R1 reset strobe", 128'(pkt_valid), 128'd0);
        chk(ctrl_idx == 2'd0, "R1 reset controller", 128'(ctrl_idx), 128'd0);
        chk(pkt_data == '0, "R1 reset buffer", pkt_data, '0);
        rst_n = 1'b1;

        // R1: first release after reset selects bit 0
        put(2'd3);
        put(2'd1);
        chk(pkt_data == 128'h1, "R1 first bit after reset", pkt_data, 128'h1);
        // R3: a repeated release does not step
        put(2'd3);
        put(2'd3);
        put(2'd1);
        chk(pkt_data == 128'h3, "R3 duplicate release ignored", pkt_data, 128'h3);
        // R2: restart mid-packet, even when repeated
        put(2'd0);
        chk(pkt_data == '0, "R2 clear mid packet", pkt_data, '0);
        put(2'd3);
        put(2'd1);
        put(2'd0);
        put(2'd0);
        chk(pkt_data == '0, "R2 repeated restart clears", pkt_data, '0);

        for (int k = 0; k < 5; k++) begin
            send_packet(pattern(k), k[0]);
        end

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 5; s++) begin
                ctrl_step(2'(m));
            end
        end

        finish_run();
    end

endmodule